// File: doc/BRIEF.md
# Packed Integer-to-Single-Precision Converter

The block takes a 64-bit operand holding two signed 32-bit integers and turns each into an IEEE-754 single-precision value in one registered stage. The two results form the low 64 bits of a 128-bit destination. The upper 64 bits of that destination are a pass-through of the destination's previous contents, which the caller supplies. A 2-bit rounding selector picks one of four rounding modes. A single inexact flag reports when either lane lost bits.

Each lane first takes the absolute value of its integer. It then counts leading zeros, shifts the most significant one up to the top, and keeps 24 significant bits. The discarded bits produce a guard bit and a sticky bit, and these drive the rounding increment. When the increment carries out of the significand, the exponent goes up by one. Infinity, overflow, underflow, denormal and invalid results cannot arise from a 32-bit integer source, so the block has no logic for them.

Top module: `pk_i2f_conv`

## Requirements
- R1: Each lane is converted on its own as a two's-complement integer: `src_ops[31:0]` goes to `dst_out[31:0]` and `src_ops[63:32]` goes to `dst_out[63:32]`. A non-zero result has sign bit 31 of its lane equal to the integer's sign, and a biased exponent between 0x7F and 0x9E.
- R2: `dst_out[127:64]` equals the `dst_hi_in` value captured with the operand.
- R3: Integer zero produces +0.0 (0x00000000) in every rounding mode.
- R4: With `rnd_mode` = 2'b00 (nearest, ties to even), 123456789 gives 0x4CEB79A3 and -123456789 gives 0xCCEB79A3. The tie cases 16777217 and 16777219 give 0x4B800000 and 0x4B800002.
- R5: With `rnd_mode` = 2'b01 (toward minus infinity), 123456789 gives 0x4CEB79A2 and -123456789 gives 0xCCEB79A3.
- R6: With `rnd_mode` = 2'b10 (toward plus infinity), 123456789 gives 0x4CEB79A3 and -123456789 gives 0xCCEB79A2.
- R7: With `rnd_mode` = 2'b11 (toward zero), 123456789 gives 0x4CEB79A2 and -123456789 gives 0xCCEB79A2. Under this mode 2147483647 gives 0x4EFFFFFF.
- R8: A rounding carry out of the significand raises the exponent. Under nearest mode, 2147483647 gives 0x4F000000 and -2147483647 gives 0xCF000000.
- R9: -2147483648 converts exactly to 0xCF000000 with `inexact` low.
- R10: `inexact` is high when any discarded bit of either lane is non-zero. Exact inputs, such as -47 (0xC23C0000) and 42 (0x42280000), leave it low.
- R11: Results and `inexact` appear on the clock edge that samples `in_valid` high, together with `out_valid` high. While `in_valid` is low, `dst_out` and `inexact` hold. Reset clears `out_valid`, `dst_out` and `inexact`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Captures an operand this cycle |
| src_ops | input | 64 | Two packed signed 32-bit integers |
| dst_hi_in | input | 64 | Prior upper half of the destination |
| rnd_mode | input | 2 | 00 nearest-even, 01 down, 10 up, 11 toward zero |
| out_valid | output | 1 | Result registered in the previous cycle |
| dst_out | output | 128 | Converted lanes in the low half, passed upper half |
| inexact | output | 1 | Precision lost in either lane |

## Verification
The clocked properties take for granted that `in_valid`, `src_ops`, `dst_hi_in` and `rnd_mode` are known and steady around each sampling edge, and that reset is held long enough to clear the result register. The bench changes inputs only on falling edges and sets all inputs to zero before it releases reset, so every sampled value is defined. The lane-level exactness check assumes nothing about the rounding selector. Stimulus therefore sweeps all four encodings with the same operands, so every increment path is taken.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int INT_W = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int FP_W  = 1 + EXP_W + MAN_W;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) count_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
  import i2f_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  localparam int FW  = 1 + EW + MW,
  localparam int CW  = $clog2(IW),
  localparam int GRD = IW - 2 - MW,
  localparam int TOPE = BIAS + IW - 1
) (
  input  logic [IW-1:0] int_i,
  input  rnd_e          rnd_i,
  output logic [FW-1:0] fp_o,
  output logic          inexact_o
);
  logic          sgn;
  logic [IW-1:0] mag;
  logic [CW-1:0] lz;
  logic [IW-1:0] norm;
  logic          guard, sticky, lost, inc;
  logic [MW+1:0] sig_sum;
  logic [EW-1:0] exp_base, exp_fin;
  logic [MW-1:0] man_fin;

  assign sgn = int_i[IW-1];
  assign mag = sgn ? (~int_i + 1'b1) : int_i;

  i2f_lzc #(.W(IW)) lzc_i (.val_i(mag), .count_o(lz));

  always_comb begin
    norm   = mag << lz;
    guard  = norm[GRD];
    sticky = |norm[GRD-1:0];
    lost   = guard | sticky;
    unique case (rnd_i)
      RND_NEAR: inc = guard & (sticky | norm[GRD+1]);
      RND_DOWN: inc = lost & sgn;
      RND_UP:   inc = lost & ~sgn;
      default:  inc = 1'b0;
    endcase
    sig_sum  = {1'b0, norm[IW-1 -: MW+1]} + {{(MW+1){1'b0}}, inc};
    exp_base = EW'(TOPE) - EW'(lz);
    if (sig_sum[MW+1]) begin
      exp_fin = exp_base + 1'b1;
      man_fin = sig_sum[MW:1];
    end else begin
      exp_fin = exp_base;
      man_fin = sig_sum[MW-1:0];
    end
    if (mag == '0) begin
      fp_o      = '0;
      inexact_o = 1'b0;
    end else begin
      fp_o      = {sgn, exp_fin, man_fin};
      inexact_o = lost;
    end
  end

  // R10: magnitudes that fit in the significand never lose bits
  always_comb begin
    if ((mag >> (MW + 1)) == '0) begin
      assert_small_exact_R10: assert (!inexact_o);
    end
  end
endmodule

// File: rtl/pk_i2f_conv.sv
module pk_i2f_conv
  import i2f_pkg::*;
#(
  parameter int LANES = 2,
  localparam int SRC_W = LANES * INT_W,
  localparam int LO_W  = LANES * FP_W,
  localparam int DST_W = 2 * LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] src_ops,
  input  logic [LO_W-1:0]  dst_hi_in,
  input  logic [1:0]       rnd_mode,
  output logic             out_valid,
  output logic [DST_W-1:0] dst_out,
  output logic             inexact
);
  logic [LO_W-1:0]  lo_res;
  logic [LANES-1:0] lane_lost;
  logic [DST_W-1:0] dst_d;
  logic             flag_d;
  rnd_e             rnd;

  assign rnd = rnd_e'(rnd_mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    i2f_lane lane_i (
      .int_i    (src_ops[g*INT_W +: INT_W]),
      .rnd_i    (rnd),
      .fp_o     (lo_res[g*FP_W +: FP_W]),
      .inexact_o(lane_lost[g])
    );
  end

  always_comb begin
    dst_d  = dst_out;
    flag_d = inexact;
    if (in_valid) begin
      dst_d  = {dst_hi_in, lo_res};
      flag_d = |lane_lost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_out   <= '0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      dst_out   <= dst_d;
      inexact   <= flag_d;
    end
  end

  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dst_out[DST_W-1:LO_W] == $past(dst_hi_in));

  assert_zero_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_ops[INT_W-1:0] == '0 |=> dst_out[FP_W-1:0] == '0);

  assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_ops[INT_W-1:0] != '0 |=> dst_out[FP_W-1] == $past(src_ops[INT_W-1]));

  assert_exp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_ops[INT_W-1:0] != '0 |=>
      dst_out[FP_W-2 -: EXP_W] >= EXP_W'(BIAS) &&
      dst_out[FP_W-2 -: EXP_W] <= EXP_W'(BIAS + INT_W - 1));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst_out) && $stable(inexact));

  assert_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
endmodule

// File: tb/pk_i2f_conv_tb_top.sv
module pk_i2f_conv_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [63:0]  src_ops;
  logic [63:0]  dst_hi_in;
  logic [1:0]   rnd_mode;
  logic         out_valid;
  logic [127:0] dst_out;
  logic         inexact;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pk_i2f_conv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_ops(src_ops),
    .dst_hi_in(dst_hi_in), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .dst_out(dst_out), .inexact(inexact)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic conv(string req, logic [31:0] a1, logic [31:0] a0,
                      logic [1:0] rm, logic [31:0] e1, logic [31:0] e0, logic ef);
    logic [63:0] up = {a0 ^ 32'h5A5A_1234, a1 ^ 32'hC3C3_8765};
    @(negedge clk);
    in_valid = 1'b1; src_ops = {a1, a0}; rnd_mode = rm; dst_hi_in = up;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " lane0"}, 128'(dst_out[31:0]), 128'(e0));
    chk({req, " lane1"}, 128'(dst_out[63:32]), 128'(e1));
    chk({req, " inexact"}, 128'(inexact), 128'(ef));
    chk("R2 upper half", 128'(dst_out[127:64]), 128'(up));
    chk("R11 out_valid", 128'(out_valid), 128'(1'b1));
  endtask

  task automatic t_zero;
    for (int m = 0; m < 4; m++) conv("R3 zero", 32'd0, 32'd0, 2'(m), 32'h0, 32'h0, 1'b0);
  endtask

  task automatic t_modes;
    conv("R4 nearest", -32'sd123456789, 32'd123456789, 2'b00, 32'hCCEB79A3, 32'h4CEB79A3, 1'b1);
    conv("R5 down",    -32'sd123456789, 32'd123456789, 2'b01, 32'hCCEB79A3, 32'h4CEB79A2, 1'b1);
    conv("R6 up",      -32'sd123456789, 32'd123456789, 2'b10, 32'hCCEB79A2, 32'h4CEB79A3, 1'b1);
    conv("R7 zero",    -32'sd123456789, 32'd123456789, 2'b11, 32'hCCEB79A2, 32'h4CEB79A2, 1'b1);
  endtask

  task automatic t_ties;
    conv("R4 tie even", 32'd16777219, 32'd16777217, 2'b00, 32'h4B800002, 32'h4B800000, 1'b1);
  endtask

  task automatic t_carry;
    conv("R8 carry", -32'sd2147483647, 32'd2147483647, 2'b00, 32'hCF000000, 32'h4F000000, 1'b1);
    conv("R7 trunc max", 32'd0, 32'd2147483647, 2'b11, 32'h0, 32'h4EFFFFFF, 1'b1);
  endtask

  task automatic t_minint;
    conv("R9 min int", 32'h8000_0000, 32'h8000_0000, 2'b01, 32'hCF000000, 32'hCF000000, 1'b0);
  endtask

  task automatic t_exact;
    conv("R10 exact", 32'd42, -32'sd47, 2'b10, 32'h42280000, 32'hC23C0000, 1'b0);
    conv("R10 one lane inexact", 32'd123456789, 32'd1, 2'b00, 32'h4CEB79A3, 32'h3F800000, 1'b1);
    conv("R1 lanes independent", 32'hFFFF_FFFF, 32'd3, 2'b00, 32'hBF800000, 32'h40400000, 1'b0);
  endtask

  task automatic t_hold;
    logic [127:0] prev_d = dst_out;
    logic prev_f = inexact;
    @(negedge clk);
    src_ops = 64'h1234_5678_9ABC_DEF0; dst_hi_in = '1; rnd_mode = 2'b11;
    @(negedge clk);
    chk("R11 hold dst", dst_out, prev_d);
    chk("R11 hold flag", 128'(inexact), 128'(prev_f));
    chk("R11 valid low", 128'(out_valid), 128'(1'b0));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_ops = '0; dst_hi_in = '0; rnd_mode = '0;
    #22;
    chk("R11 reset dst", dst_out, '0);
    chk("R11 reset flag", 128'(inexact), 128'(1'b0));
    chk("R11 reset valid", 128'(out_valid), 128'(1'b0));
    @(negedge clk); rst_n = 1'b1;
    t_zero; t_modes; t_ties; t_carry; t_minint; t_exact; t_hold;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule